// File: doc/BRIEF.md
# Command Window Slot Allocator

The allocator bounds command-bus bandwidth. Time is split into fixed windows of 2^WIN_LOG2 time units. For each window it keeps a count of the commands already booked there, with one set of counts for row commands and a separate set for column commands. A requester presents a proposed issue time, a command class and a per-window limit. The block then searches forward from the window that holds the proposed time for the first window of that class whose count is below the limit. It returns the earliest time it allows and books one command in the window it picked.

The counts sit in a circular table of N_WIN windows. Slot `w mod N_WIN` holds absolute window `w`. The table spans the window containing `now_time` and the N_WIN-1 windows after it. When `now_time` moves into a later window, every window that now lies before it is released in both classes. That release happens in the same cycle as any request, and the request sees the table after the release. A request that cannot be placed inside the span raises `busy` and books nothing. The requester holds the request until it is granted.

Top module: `cwa_cmd_slot_alloc`

## Requirements
- R1: After reset every window of both classes is empty. `grant_valid` is 0, and `busy` is 0 while `req_valid` is 0.
- R2: The window key of a time is the time shifted right by WIN_LOG2 bits (default window length 8). A window starts at key × 8.
- R3: If the window holding `req_time` has a count below `req_limit` for the class, the request is accepted. In the next cycle `grant_valid` is 1 and `grant_time` equals `req_time`.
- R4: If the target window is at or above the limit, the search moves one window at a time. `grant_time` is the start time of the first later window with room.
- R5: Each grant adds one to the count of the granted window for that class only.
- R6: `req_col`=0 selects row counts and `req_col`=1 selects column counts. Bookings of one class never use capacity of the other.
- R7: A window whose key is below the key of `now_time` is released in both classes, and a later request to that slot sees it empty.
- R8: `busy` is 1 and nothing is booked or granted in three cases: the request's window is before the current window, it lies N_WIN or more windows ahead, or no window with room exists up to the end of the span.
- R9: A release and a request in the same cycle are resolved release first, so a request may be granted in a slot freed that cycle.
- R10: A request with `req_limit`=0 is always `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| now_time | input | TIME_W | Current time; sets the current window and drives release |
| req_valid | input | 1 | Request present |
| req_col | input | 1 | 0 = row command, 1 = column command |
| req_limit | input | CNT_W | Maximum commands per window for this request |
| req_time | input | TIME_W | Proposed issue time |
| busy | output | 1 | Request cannot be placed this cycle (combinational) |
| grant_valid | output | 1 | A request was booked in the previous cycle |
| grant_time | output | TIME_W | Granted issue time |

## Verification
Release of past windows and a new booking can happen in the same cycle. Both want the same circular slot when the request targets a window exactly N_WIN ahead of a window that has just expired. The bench provokes this by fully booking window 0, then advancing `now_time` into window 1 while requesting a time in window 4, which maps to slot 0. It judges the result by requiring an undeferred grant at the requested time. A model that books before releasing would defer that request or stall it.

// File: rtl/cwa_pkg.sv
// Package: shared types for the command window slot allocator.
// Assumes nothing beyond IEEE 1800-2017.
package cwa_pkg;
    // Command class selects which count table a request uses
    typedef enum logic {
        CLS_ROW = 1'b0,
        CLS_COL = 1'b1
    } cmd_cls_e;
endpackage

// File: rtl/cwa_prune_mask.sv
// Module: cwa_prune_mask
// Flags the circular slots whose window has fallen behind the current window.
// Assumes the current window never moves backwards. Slot i holds the unique
// window w in [cur_q, cur_q+N_WIN-1] with w mod N_WIN == i.
module cwa_prune_mask #(
    parameter int WN_W  = 13,
    parameter int N_WIN = 4,
    parameter int IDX_W = $clog2(N_WIN)
) (
    input  logic [WN_W-1:0]  cur_q,
    input  logic [WN_W-1:0]  cur_new,
    output logic [N_WIN-1:0] stale
);
    logic [WN_W-1:0] adv;

    // how many windows the current window moved since last cycle
    assign adv = cur_new - cur_q;

    for (genvar i = 0; i < N_WIN; i++) begin : g_slot
        logic [IDX_W-1:0] off;
        // distance of slot i from the old current window
        assign off      = IDX_W'(i) - cur_q[IDX_W-1:0];
        assign stale[i] = adv > WN_W'(off);
    end
endmodule

// File: rtl/cwa_slot_search.sv
// Module: cwa_slot_search
// Finds the first slot at or after start_off (counted from the current window)
// whose count is below the limit. Assumes N_WIN is a power of two.
module cwa_slot_search #(
    parameter int N_WIN = 4,
    parameter int IDX_W = $clog2(N_WIN),
    parameter int CNT_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_WIN-1:0][CNT_W-1:0] counts,
    input  logic [IDX_W-1:0]            cur_slot,
    input  logic [IDX_W-1:0]            start_off,
    input  logic [CNT_W-1:0]            limit,
    output logic                        found,
    output logic [IDX_W-1:0]            hit_off
);
    // priority scan from the start offset to the end of the span
    always_comb begin
        found   = 1'b0;
        hit_off = '0;
        for (int k = 0; k < N_WIN; k++) begin
            if (!found && IDX_W'(k) >= start_off &&
                counts[IDX_W'(cur_slot + IDX_W'(k))] < limit) begin
                found   = 1'b1;
                hit_off = IDX_W'(k);
            end
        end
    end

    // R4: the scan never picks a window before the requested one
    p_hit_not_before_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> hit_off >= start_off);
    // R10: a zero limit leaves no slot with room
    p_zero_limit_no_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        limit == '0 |-> !found);
endmodule

// File: rtl/cwa_cmd_slot_alloc.sv
// Module: cwa_cmd_slot_alloc
// Books row or column commands into fixed time windows under a per-window
// limit. It grants the proposed time, or the start of the first later window
// with room, and releases windows behind now_time. Assumes now_time does not
// decrease and that a stalled request is held until granted.
module cwa_cmd_slot_alloc #(
    parameter int TIME_W   = 16,
    parameter int WIN_LOG2 = 3,
    parameter int N_WIN    = 4,
    parameter int CNT_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] now_time,
    input  logic              req_valid,
    input  logic              req_col,
    input  logic [CNT_W-1:0]  req_limit,
    input  logic [TIME_W-1:0] req_time,
    output logic              busy,
    output logic              grant_valid,
    output logic [TIME_W-1:0] grant_time
);
    import cwa_pkg::*;

    localparam int WN_W  = TIME_W - WIN_LOG2;
    localparam int IDX_W = $clog2(N_WIN);

    logic [WN_W-1:0]  cur_q, cur_new, req_win, req_dist;
    logic [N_WIN-1:0] stale;
    logic             in_span, found, book, deferred;
    logic [IDX_W-1:0] hit_off, hit_slot;
    logic [TIME_W-1:0] grant_nxt;
    cmd_cls_e         cls;
    logic [N_WIN-1:0][CNT_W-1:0] eff_all [2];
    logic [N_WIN-1:0][CNT_W-1:0] sel_cnt;

    // window keys of the current time and of the request
    assign cur_new  = now_time[TIME_W-1:WIN_LOG2];
    assign req_win  = req_time[TIME_W-1:WIN_LOG2];
    assign req_dist = req_win - cur_new;
    assign in_span  = req_dist < WN_W'(N_WIN);
    assign cls      = cmd_cls_e'(req_col);

    cwa_prune_mask #(.WN_W(WN_W), .N_WIN(N_WIN), .IDX_W(IDX_W)) u_prune (
        .cur_q   (cur_q),
        .cur_new (cur_new),
        .stale   (stale)
    );

    // one count table per command class, pruned before the search sees it
    for (genvar c = 0; c < 2; c++) begin : g_cls
        logic [N_WIN-1:0][CNT_W-1:0] cnt_q;
        for (genvar i = 0; i < N_WIN; i++) begin : g_ent
            // released slots read as empty in the same cycle
            assign eff_all[c][i] = stale[i] ? '0 : cnt_q[i];

            // hold, clear or increment this slot's count
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cnt_q[i] <= '0;
                else if (book && cls == cmd_cls_e'(c) && hit_slot == IDX_W'(i))
                    cnt_q[i] <= eff_all[c][i] + CNT_W'(1);
                else
                    cnt_q[i] <= eff_all[c][i];
            end

            // R5: a count only ever steps up by one
            p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_q[i] > $past(cnt_q[i]) |-> cnt_q[i] == $past(cnt_q[i]) + CNT_W'(1));
        end
    end

    assign sel_cnt = eff_all[req_col];

    cwa_slot_search #(.N_WIN(N_WIN), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_search (
        .clk       (clk),
        .rst_n     (rst_n),
        .counts    (sel_cnt),
        .cur_slot  (cur_new[IDX_W-1:0]),
        .start_off (req_dist[IDX_W-1:0]),
        .limit     (req_limit),
        .found     (found),
        .hit_off   (hit_off)
    );

    // accept decision and granted time
    assign book      = req_valid && in_span && found;
    assign busy      = req_valid && !book;
    assign hit_slot  = cur_new[IDX_W-1:0] + hit_off;
    assign deferred  = hit_off != req_dist[IDX_W-1:0];
    assign grant_nxt = deferred ? {cur_new + WN_W'(hit_off), {WIN_LOG2{1'b0}}} : req_time;

    // register the grant and track the current window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q       <= '0;
            grant_valid <= 1'b0;
            grant_time  <= '0;
        end else begin
            cur_q       <= cur_new;
            grant_valid <= book;
            if (book)
                grant_time <= grant_nxt;
        end
    end

    // R4: a grant is never earlier than the request
    p_grant_not_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> grant_time >= $past(req_time));
    // R4: a moved grant lands on a window start
    p_defer_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && grant_time != $past(req_time)) |-> grant_time[WIN_LOG2-1:0] == '0);
    // R8: a grant stays inside the table span
    p_grant_in_span_r8: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (grant_time[TIME_W-1:WIN_LOG2] - $past(now_time[TIME_W-1:WIN_LOG2]))
                        < WN_W'(N_WIN));
    // R8: a stalled request produces no grant
    p_busy_no_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !grant_valid);
    // R10: a zero limit always stalls
    p_zero_limit_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_limit == '0) |-> busy);
endmodule

// File: tb/sim_cwa_cmd_slot_alloc.sv
// Bench: walks a vector table, then directed reset and corner tests.
module sim_cwa_cmd_slot_alloc;
    localparam int TIME_W = 16;
    localparam int CNT_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [TIME_W-1:0] now_time = '0;
    logic              req_valid = 1'b0;
    logic              req_col = 1'b0;
    logic [CNT_W-1:0]  req_limit = '0;
    logic [TIME_W-1:0] req_time = '0;
    logic              busy, grant_valid;
    logic [TIME_W-1:0] grant_time;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    cwa_cmd_slot_alloc u0 (
        .clk(clk), .rst_n(rst_n), .now_time(now_time), .req_valid(req_valid),
        .req_col(req_col), .req_limit(req_limit), .req_time(req_time),
        .busy(busy), .grant_valid(grant_valid), .grant_time(grant_time)
    );

    typedef struct packed {
        logic [15:0] now;
        logic        vld;
        logic        col;
        logic [3:0]  lim;
        logic [15:0] t;
        logic        ebusy;
        logic [15:0] egt;
    } vec_t;

    // window length 8, four windows in the table
    localparam vec_t VEC [16] = '{
        '{16'd0,  1'b1, 1'b0, 4'd2, 16'd3,  1'b0, 16'd3 },  // R3 first row in win0
        '{16'd0,  1'b1, 1'b0, 4'd2, 16'd5,  1'b0, 16'd5 },  // R5 win0 row now 2
        '{16'd0,  1'b1, 1'b0, 4'd2, 16'd6,  1'b0, 16'd8 },  // R4 win0 full -> win1
        '{16'd0,  1'b1, 1'b1, 4'd2, 16'd2,  1'b0, 16'd2 },  // R6 column unaffected
        '{16'd0,  1'b1, 1'b0, 4'd1, 16'd9,  1'b0, 16'd16},  // R4 win1 has 1 -> win2
        '{16'd0,  1'b1, 1'b0, 4'd1, 16'd0,  1'b0, 16'd24},  // R4 scan to win3
        '{16'd0,  1'b1, 1'b0, 4'd1, 16'd1,  1'b1, 16'd0 },  // R8 no room in span
        '{16'd0,  1'b1, 1'b0, 4'd3, 16'd33, 1'b1, 16'd0 },  // R8 window 4 too far
        '{16'd0,  1'b1, 1'b0, 4'd0, 16'd20, 1'b1, 16'd0 },  // R10 zero limit
        '{16'd8,  1'b1, 1'b0, 4'd2, 16'd33, 1'b0, 16'd33},  // R9 slot0 freed same cycle
        '{16'd8,  1'b1, 1'b0, 4'd2, 16'd8,  1'b0, 16'd8 },  // R2 win1 row has 1
        '{16'd8,  1'b1, 1'b1, 4'd1, 16'd4,  1'b1, 16'd0 },  // R8 window behind now
        '{16'd8,  1'b1, 1'b1, 4'd1, 16'd12, 1'b0, 16'd12},  // R6 column win1 empty
        '{16'd40, 1'b1, 1'b0, 4'd1, 16'd40, 1'b0, 16'd40},  // R7 all old released
        '{16'd40, 1'b1, 1'b0, 4'd1, 16'd41, 1'b0, 16'd48},  // R4 win5 full -> win6
        '{16'd40, 1'b0, 1'b0, 4'd1, 16'd41, 1'b0, 16'd0 }   // R1 idle: no busy
    };

    string tags [16] = '{"R3","R5","R4","R6","R4","R4","R8","R8","R10",
                         "R9","R2","R8","R6","R7","R4","R1"};

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // drive at the falling edge, check busy, then the grant after the next edge
    task automatic apply(input vec_t v, input string tag);
        now_time  = v.now;
        req_valid = v.vld;
        req_col   = v.col;
        req_limit = v.lim;
        req_time  = v.t;
        #1;
        check(tag, "busy", 32'(busy), 32'(v.ebusy));
        @(negedge clk);
        check(tag, "grant_valid", 32'(grant_valid), 32'(v.vld && !v.ebusy));
        if (v.vld && !v.ebusy)
            check(tag, "grant_time", 32'(grant_time), 32'(v.egt));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1", "grant_valid after reset", 32'(grant_valid), 32'd0);
        check("R1", "busy idle after reset", 32'(busy), 32'd0);
        @(negedge clk);

        for (int i = 0; i < 16; i++)
            apply(VEC[i], tags[i]);

        // R1: reset empties a full window (win5 row holds 1 at limit 1)
        rst_n = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        apply('{16'd40, 1'b1, 1'b0, 4'd1, 16'd42, 1'b0, 16'd42}, "R1");

        // R6: column win5 fills independently of row at limit 1
        apply('{16'd40, 1'b1, 1'b1, 4'd1, 16'd43, 1'b0, 16'd43}, "R6");
        apply('{16'd40, 1'b1, 1'b1, 4'd1, 16'd44, 1'b0, 16'd48}, "R6");

        // R7: step into window 6; row win6 count 0 after win5 released
        apply('{16'd48, 1'b1, 1'b0, 4'd1, 16'd50, 1'b0, 16'd50}, "R7");
        // R8: request at last slot of span (win9) is allowed
        apply('{16'd48, 1'b1, 1'b0, 4'd1, 16'd79, 1'b0, 16'd79}, "R8");

        req_valid = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule